// File: doc/BRIEF.md
# YCbCr-to-RGB Colour Matrix

This block turns 10-bit YCbCr pixels of a display plane into 10-bit RGB. Each input component gets a signed offset and is then clamped to a per-channel window. The clamped vector, ordered (Cr, Y, Cb), is multiplied by a 3x3 matrix of signed s3.12 coefficients. Each row sum is rounded, shifted back to integer scale, given an output offset and saturated to 0..1023. Chroma arrives as two's-complement values. Data is treated as full range on both sides.

Software writes its settings into a shadow register set. The settings reach the datapath only when the display pulses `frame_start`, so a frame never mixes two configurations. A strobe can fill the shadow coefficients with the BT.601 or BT.709 preset in one cycle. A pixel flagged as RGB passes through unchanged, with the same latency as the matrix path. The datapath is three registers deep: clamp, multiply, then sum and saturate.

Top module: `ycc_rgb_csc`

## Requirements
- R1: Reset clears `out_valid`. The active and shadow coefficients take the BT.601 preset. All offsets are zero. The clamp windows are 0..1023 for Y and -512..512 for Cb and Cr.
- R2: Each pixel with `in_valid` high leaves exactly three clock edges later with `out_valid` high. Pixels keep their order, and back-to-back pixels are accepted every cycle.
- R3: With `is_rgb` high, the output is `out_r`=`pix_cr`, `out_g`=`pix_y` and `out_b`=`pix_cb`, bit for bit. Offsets, clamps and the matrix do not touch it.
- R4: For YCbCr pixels, with v = (Cr, Y, Cb) after offset and clamp, each output is (c[3j]*v0 + c[3j+1]*v1 + c[3j+2]*v2 + 2048) arithmetically shifted right by 12. Rows j = 0, 1, 2 give R, G, B. Y is unsigned; Cb and Cr are 10-bit two's complement.
- R5: A `load_preset` strobe writes a preset into the shadow coefficients. `enc_sel`=0 selects BT.601 {5743,4096,0; -2925,4096,-1410; 0,4096,7258}. `enc_sel`=1 selects BT.709 {6450,4096,0; -1917,4096,-767; 0,4096,7601}.
- R6: Register writes and preset loads change only the shadow set. The datapath keeps its previous settings until the clock edge where `frame_start` is high, which copies the whole shadow set into the active set.
- R7: Register map, with a write taking effect when `cfg_we` is high:
  - Addresses 0..3 take c[2a] in bits 15:0 and c[2a+1] in bits 31:16.
  - Address 4 takes c8 in bits 15:0.
  - Address 5+k takes the input offset of vector element k (0 Cr, 1 Y, 2 Cb) in bits 15:0, and the output offset of output k (0 R, 1 G, 2 B) in bits 31:16.
  - Address 8+k takes the clamp minimum of element k in bits 15:0 and its maximum in bits 31:16.
  - All fields are 16-bit two's complement.
- R8: Each input element is offset before it is clamped. A value below the minimum becomes the minimum, and a value above the maximum becomes the maximum.
- R9: The output offset is added after the shift. The result is saturated: below 0 gives 0, above 1023 gives 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 4 | Shadow register address |
| cfg_wdata | input | 32 | Shadow register write data |
| load_preset | input | 1 | Load preset coefficients into the shadow set |
| enc_sel | input | 1 | Preset choice: 0 BT.601, 1 BT.709 |
| frame_start | input | 1 | Copy the shadow set to the active set |
| in_valid | input | 1 | Input pixel valid |
| is_rgb | input | 1 | Pixel is RGB and bypasses the matrix |
| pix_y | input | 10 | Y (or G), unsigned |
| pix_cb | input | 10 | Cb (or B), two's complement |
| pix_cr | input | 10 | Cr (or R), two's complement |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 10 | Red |
| out_g | output | 10 | Green |
| out_b | output | 10 | Blue |

## Verification
Pixel patterns and what each one shows:
- Neutral grey (zero chroma) under both presets shows that the Y column alone reproduces luma.
- Extreme chroma at both signs drives rows past 1023 and below 0, which exercises saturation at each end.
- A permutation matrix (R from Y, G from Cb, B from Cr) exposes any swap in the coefficient packing or in the vector order.
- Offsets pushed past the clamp windows separate offset-then-clamp from the reverse order.
- Interleaved RGB and YCbCr pixels sent back to back show that the bypass and the matrix path stay aligned.
- Pixels sent between a write and the next `frame_start` tell shadow settings apart from active ones.

// File: rtl/ycc_rgb_csc.sv
module ycc_rgb_csc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        load_preset,
  input  logic        enc_sel,
  input  logic        frame_start,
  input  logic        in_valid,
  input  logic        is_rgb,
  input  logic [9:0]  pix_y,
  input  logic [9:0]  pix_cb,
  input  logic [9:0]  pix_cr,
  output logic        out_valid,
  output logic [9:0]  out_r,
  output logic [9:0]  out_g,
  output logic [9:0]  out_b
);

  function automatic logic signed [15:0] preset_c(input logic sel, input int i);
    case (i)
      0:       return sel ? 16'sd6450  : 16'sd5743;
      1, 4, 7: return 16'sd4096;
      3:       return sel ? -16'sd1917 : -16'sd2925;
      5:       return sel ? -16'sd767  : -16'sd1410;
      8:       return sel ? 16'sd7601  : 16'sd7258;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic logic signed [15:0] def_lo(input int k);
    return (k == 1) ? 16'sd0 : -16'sd512;
  endfunction

  function automatic logic signed [15:0] def_hi(input int k);
    return (k == 1) ? 16'sd1023 : 16'sd512;
  endfunction

  logic signed [15:0] sh_c [9];
  logic signed [15:0] ac_c [9];
  logic signed [15:0] sh_io [3], sh_oo [3], sh_lo [3], sh_hi [3];
  logic signed [15:0] ac_io [3], ac_oo [3], ac_lo [3], ac_hi [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) begin
        sh_c[i] <= preset_c(1'b0, i);
        ac_c[i] <= preset_c(1'b0, i);
      end
      for (int k = 0; k < 3; k++) begin
        sh_io[k] <= '0; sh_oo[k] <= '0; sh_lo[k] <= def_lo(k); sh_hi[k] <= def_hi(k);
        ac_io[k] <= '0; ac_oo[k] <= '0; ac_lo[k] <= def_lo(k); ac_hi[k] <= def_hi(k);
      end
    end else begin
      if (cfg_we) begin
        for (int a = 0; a < 4; a++)
          if (cfg_addr == 4'(a)) begin
            sh_c[2*a]   <= cfg_wdata[15:0];
            sh_c[2*a+1] <= cfg_wdata[31:16];
          end
        if (cfg_addr == 4'd4) sh_c[8] <= cfg_wdata[15:0];
        for (int k = 0; k < 3; k++) begin
          if (cfg_addr == 4'(5 + k)) begin
            sh_io[k] <= cfg_wdata[15:0];
            sh_oo[k] <= cfg_wdata[31:16];
          end
          if (cfg_addr == 4'(8 + k)) begin
            sh_lo[k] <= cfg_wdata[15:0];
            sh_hi[k] <= cfg_wdata[31:16];
          end
        end
      end
      if (load_preset)
        for (int i = 0; i < 9; i++) sh_c[i] <= preset_c(enc_sel, i);
      if (frame_start) begin
        for (int i = 0; i < 9; i++) ac_c[i] <= sh_c[i];
        for (int k = 0; k < 3; k++) begin
          ac_io[k] <= sh_io[k]; ac_oo[k] <= sh_oo[k];
          ac_lo[k] <= sh_lo[k]; ac_hi[k] <= sh_hi[k];
        end
      end
    end
  end

  // stage 1: offset then clamp, vector order Cr, Y, Cb
  logic signed [17:0] xin [3];
  assign xin[0] = {{8{pix_cr[9]}}, pix_cr} + {{2{ac_io[0][15]}}, ac_io[0]};
  assign xin[1] = {8'b0, pix_y}            + {{2{ac_io[1][15]}}, ac_io[1]};
  assign xin[2] = {{8{pix_cb[9]}}, pix_cb} + {{2{ac_io[2][15]}}, ac_io[2]};

  logic               s1_vld, s2_vld;
  logic               s1_rgb, s2_rgb;
  logic [29:0]        s1_raw, s2_raw;
  logic signed [15:0] s1_v [3];
  logic signed [33:0] s2_p [9];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s2_vld <= 1'b0; out_valid <= 1'b0;
    end else begin
      s1_vld <= in_valid; s2_vld <= s1_vld; out_valid <= s2_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_rgb <= is_rgb;
      s1_raw <= {pix_cr, pix_y, pix_cb};
      for (int k = 0; k < 3; k++)
        s1_v[k] <= (xin[k] < 18'(ac_lo[k])) ? ac_lo[k] :
                   (xin[k] > 18'(ac_hi[k])) ? ac_hi[k] : xin[k][15:0];
    end
  end

  // stage 2: nine products
  always_ff @(posedge clk) begin
    if (s1_vld) begin
      s2_rgb <= s1_rgb;
      s2_raw <= s1_raw;
      for (int i = 0; i < 9; i++)
        s2_p[i] <= 34'(ac_c[i]) * 34'(s1_v[i % 3]);
    end
  end

  // stage 3: row sums, rounding, output offset, saturation
  logic signed [33:0] acc [3];
  logic signed [33:0] res [3];
  logic [9:0]         sat [3];

  for (genvar j = 0; j < 3; j++) begin : g_row
    assign acc[j] = s2_p[3*j] + s2_p[3*j+1] + s2_p[3*j+2] + 34'sd2048;
    assign res[j] = (acc[j] >>> 12) + 34'(ac_oo[j]);
    assign sat[j] = (res[j] < 34'sd0)    ? 10'd0 :
                    (res[j] > 34'sd1023) ? 10'd1023 : res[j][9:0];
  end

  always_ff @(posedge clk) begin
    if (s2_vld) begin
      out_r <= s2_rgb ? s2_raw[29:20] : sat[0];
      out_g <= s2_rgb ? s2_raw[19:10] : sat[1];
      out_b <= s2_rgb ? s2_raw[9:0]   : sat[2];
    end
  end

  // R2: every output beat was accepted three edges earlier
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  // R3: bypass pixels arrive bit-exact
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_valid && is_rgb, 3) |->
      out_r == $past(pix_cr, 3) && out_g == $past(pix_y, 3) && out_b == $past(pix_cb, 3));

  for (genvar i = 0; i < 9; i++) begin : g_hold
    // R6: active coefficients move only on frame_start
    a_r6_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(ac_c[i]));
  end

  for (genvar k = 0; k < 3; k++) begin : g_clamp
    // R8: clamped element lies inside the active window
    a_r8_clamp_window: assert property (@(posedge clk) disable iff (!rst_n)
      s1_vld && !$past(frame_start) && ac_lo[k] <= ac_hi[k] |->
        s1_v[k] >= ac_lo[k] && s1_v[k] <= ac_hi[k]);
  end

endmodule

// File: tb/test_ycc_rgb_csc.sv
module test_ycc_rgb_csc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        load_preset = 1'b0;
  logic        enc_sel = 1'b0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        is_rgb = 1'b0;
  logic [9:0]  pix_y = '0, pix_cb = '0, pix_cr = '0;
  logic        out_valid;
  logic [9:0]  out_r, out_g, out_b;

  always #10 clk = ~clk;

  ycc_rgb_csc i_ycc_rgb_csc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .load_preset(load_preset), .enc_sel(enc_sel), .frame_start(frame_start),
    .in_valid(in_valid), .is_rgb(is_rgb), .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b));

  typedef struct { logic [9:0] r, g, b; string tag; } exp_t;
  exp_t q[$];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int mc[9], sc[9];
  int mio[3], moo[3], mlo[3], mhi[3];
  int sio[3], soo[3], slo[3], shi[3];

  function automatic int pre(input bit sel, input int i);
    int t601[9] = '{5743, 4096, 0, -2925, 4096, -1410, 0, 4096, 7258};
    int t709[9] = '{6450, 4096, 0, -1917, 4096, -767, 0, 4096, 7601};
    return sel ? t709[i] : t601[i];
  endfunction

  function automatic int s16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [31:0] pk(input int hi, input int lo);
    return {16'(hi), 16'(lo)};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 9; i++) begin mc[i] = pre(0, i); sc[i] = mc[i]; end
    for (int k = 0; k < 3; k++) begin
      mio[k] = 0; moo[k] = 0; mlo[k] = (k == 1) ? 0 : -512; mhi[k] = (k == 1) ? 1023 : 512;
      sio[k] = 0; soo[k] = 0; slo[k] = mlo[k]; shi[k] = mhi[k];
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    if (a < 4) begin sc[2*a] = s16(d[15:0]); sc[2*a+1] = s16(d[31:16]); end
    else if (a == 4) sc[8] = s16(d[15:0]);
    else if (a < 8) begin sio[a-5] = s16(d[15:0]); soo[a-5] = s16(d[31:16]); end
    else begin slo[a-8] = s16(d[15:0]); shi[a-8] = s16(d[31:16]); end
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic preset(input bit s);
    for (int i = 0; i < 9; i++) sc[i] = pre(s, i);
    @(negedge clk); load_preset = 1'b1; enc_sel = s;
    @(negedge clk); load_preset = 1'b0;
  endtask

  task automatic fstart();
    mc = sc; mio = sio; moo = soo; mlo = slo; mhi = shi;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic px(input int y, input int cb, input int cr, input bit rgb, input string tag);
    exp_t e;
    longint v[3];
    longint t;
    logic [9:0] o[3];
    e.tag = tag;
    if (rgb) begin
      e.r = 10'(cr); e.g = 10'(y); e.b = 10'(cb);
    end else begin
      v[0] = cr; v[1] = y; v[2] = cb;
      for (int k = 0; k < 3; k++) begin
        v[k] = v[k] + mio[k];
        if (v[k] < mlo[k]) v[k] = mlo[k];
        else if (v[k] > mhi[k]) v[k] = mhi[k];
      end
      for (int j = 0; j < 3; j++) begin
        t = mc[3*j] * v[0] + mc[3*j+1] * v[1] + mc[3*j+2] * v[2];
        t = ((t + 2048) >>> 12) + moo[j];
        o[j] = (t < 0) ? 10'd0 : (t > 1023) ? 10'd1023 : 10'(t);
      end
      e.r = o[0]; e.g = o[1]; e.b = o[2];
    end
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b1; is_rgb = rgb; pix_y = 10'(y); pix_cb = 10'(cb); pix_cr = 10'(cr);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      exp_t e;
      n_tests++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected output: actual %0d/%0d/%0d expected none", out_r, out_g, out_b);
      end else begin
        e = q.pop_front();
        if (out_r !== e.r || out_g !== e.g || out_b !== e.b) begin
          n_fail++;
          $display("FAIL %s: actual %0d/%0d/%0d expected %0d/%0d/%0d",
                   e.tag, out_r, out_g, out_b, e.r, e.g, e.b);
        end
      end
    end
  end

  task automatic summary();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1 out_valid in reset: actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4: reset defaults give BT.601, patterns across the chroma plane
    px(512, 0, 0, 0, "R1 R4 grey");
    px(300, 100, -50, 0, "R4 mixed");
    px(700, -200, 150, 0, "R4 mixed2");
    px(1023, 0, 511, 0, "R9 high sat");
    px(0, -512, -512, 0, "R9 low sat");
    px(200, 511, -300, 0, "R4 blue high");
    // R2 R3: interleaved bypass and matrix beats
    px(5, -3, 700, 1, "R3 bypass");
    px(400, 50, 60, 0, "R2 order");
    px(1023, 511, -512, 1, "R3 bypass2");
    px(0, 0, 0, 1, "R3 bypass zero");
    idle(5);

    // R7: permutation matrix R=Y, G=Cb, B=Cr held in shadow
    wr(0, pk(4096, 0));
    wr(1, pk(0, 0));
    wr(2, pk(4096, 0));
    wr(3, pk(0, 4096));
    wr(4, pk(0, 0));
    px(100, 200, 300, 0, "R6 shadow not active");
    idle(5);
    fstart();
    px(100, 200, 300, 0, "R7 permute");
    px(900, -100, 45, 0, "R7 permute neg");
    idle(5);

    // R8 R9: offsets and clamps
    wr(5, pk(0, 50));
    wr(6, pk(-20, 100));
    wr(7, pk(600, 0));
    wr(10, pk(150, -512));
    fstart();
    px(1000, 300, 500, 0, "R8 clamp high");
    px(0, -100, -512, 0, "R9 offsets");
    px(500, 10, 0, 0, "R8 R9 mid");
    idle(5);

    // R5: BT.709 preset
    wr(5, pk(0, 0));
    wr(6, pk(0, 0));
    wr(7, pk(0, 0));
    wr(10, pk(512, -512));
    preset(1);
    fstart();
    px(512, 0, 0, 0, "R5 709 grey");
    px(300, 100, -50, 0, "R5 709 mixed");
    px(600, -400, 400, 0, "R5 709 chroma");
    idle(5);
    preset(0);
    px(300, 100, -50, 0, "R6 preset pending");
    idle(5);
    fstart();
    px(300, 100, -50, 0, "R5 601 back");
    idle(10);

    n_tests++;
    if (q.size() != 0) begin
      n_fail++; $display("FAIL R2 missing outputs: actual %0d left expected 0", q.size());
    end
    summary();
  end

endmodule